// File: doc/BRIEF.md
# Data Address Translation Fault Checker

This block takes one data load or store request per cycle and turns its virtual address into a physical address. On the way it decides whether the access must fault. Alignment is tested first. A request marked as physical then skips all translation. Next the address is tested for correct sign extension, then for the kernel-only direct-mapped window. Every remaining access is translated through an external TLB lookup. The TLB array and the page walk sit outside the block: it presents the virtual page number and address-space number on combinational outputs and expects hit, frame number and per-mode enable bits back in the same cycle.

The result is registered. One cycle after a request, the block presents the physical address, a two-bit fault code and a four-bit status word. Six counters record translated read and write accesses, TLB misses and access violations, split by direction. In privileged-code mode the privilege level used for the TLB permission test can be redirected to a separate alternate-mode register.

Top module: `dtx_fault_check`

## Requirements
- R1: A request with any of the low address bits selected by the size code set (size code 0/1/2/3 = 1/2/4/8 bytes) returns fault code 1 (alignment). This takes precedence over every other check, even for a physical request. Its status has only bit 0 set, and only for a store. No counter moves.
- R2: An aligned request flagged physical returns fault code 0, and the physical address is the low 44 bits of the virtual address. No lookup is issued and no counter moves.
- R3: An aligned, non-physical request whose bits [63:43] are not all equal to bit 42 returns fault code 2 (page fault). Its status is 0xB for a store and 0xA for a load (bit 0 write, bit 1 violation, bit 3 bad address). It increments the read or write violation counter and ignores the TLB inputs.
- R4: A valid address with bits [47:41] equal to 7'h7e takes the direct-mapped path without a lookup. When the current-mode register is 0 (kernel), fault code is 0 and the physical address is bits [43:0], with bits [43:40] forced to all ones if bit 40 is set and to zero otherwise. In any other mode the request returns fault code 3 (access violation), status write|violation, and increments the violation counter.
- R5: The kernel test on the direct-mapped path uses the current-mode register even in privileged-code mode, where the alternate selection would otherwise give kernel.
- R6: In privileged-code mode the effective mode is the alternate-mode register when the request carries the alternate flag, and kernel (0) otherwise. Outside privileged-code mode the effective mode is the current-mode register and the alternate flag has no effect.
- R7: Every other request drives a lookup with page number bits [42:13] and the current address-space number, and increments the read or write access counter. A miss returns fault code 2 with status bit 0 set only for a store, and increments the read or write miss counter.
- R8: On a hit the physical address is {frame number, address bits [12:0]}. The read-enable (load) or write-enable (store) bit indexed by the effective mode must be set. Otherwise the request returns fault code 3 with status write|violation and increments the violation counter.
- R9: Results appear one cycle after the request with a valid flag. A cycle without a request yields no valid result and changes no counter. Reset clears the valid flag and all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_size | input | 2 | Access size code (log2 bytes) |
| req_write | input | 1 | 1 for a store |
| req_phys | input | 1 | Bypass translation |
| req_alt | input | 1 | Use alternate mode in privileged-code mode |
| pal_mode | input | 1 | Executing privileged code |
| cur_mode | input | 2 | Current-mode register |
| alt_mode | input | 2 | Alternate-mode register |
| cur_asn | input | 8 | Current address-space number |
| tlb_lookup | output | 1 | Lookup issued this cycle |
| tlb_vpn | output | 30 | Virtual page number for lookup |
| tlb_asn | output | 8 | Address-space number for lookup |
| tlb_hit | input | 1 | Lookup hit |
| tlb_ppn | input | 31 | Physical frame number on hit |
| tlb_rd_en | input | 4 | Per-mode read enables |
| tlb_wr_en | input | 4 | Per-mode write enables |
| rsp_valid | output | 1 | Result valid |
| rsp_paddr | output | 44 | Physical address |
| rsp_fault | output | 2 | 0 none, 1 alignment, 2 page, 3 violation |
| rsp_status | output | 4 | Status word (bit0 write, bit1 violation, bit3 bad address) |
| cnt_rd_acc | output | 16 | Translated loads |
| cnt_wr_acc | output | 16 | Translated stores |
| cnt_rd_miss | output | 16 | Load misses |
| cnt_wr_miss | output | 16 | Store misses |
| cnt_rd_acv | output | 16 | Load violations |
| cnt_wr_acv | output | 16 | Store violations |

## Verification
The lookup outputs are combinational, so the bench samples them just after driving a request and before the next rising edge. Address, fault code and status come out of one register stage, and the bench reads them at the falling edge after the edge that captured the request. The counters update on that same edge. The bench sums the expected increments of every vector and compares the totals only after an idle cycle, in which it also confirms that the valid flag and the counters stay put.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_ALIGN = 2'd1,
    FLT_PAGE  = 2'd2,
    FLT_ACV   = 2'd3
  } flt_e;

  localparam int ST_W     = 4;
  localparam int ST_WR    = 0;
  localparam int ST_ACV   = 1;
  localparam int ST_BADVA = 3;

  localparam int MODE_W      = 2;
  localparam logic [1:0] MODE_KERNEL = 2'd0;

  localparam int NCNT       = 6;
  localparam int CI_RD_ACC  = 0;
  localparam int CI_RD_MISS = 2;
  localparam int CI_RD_ACV  = 4;
endpackage

// File: rtl/dtx_addr_class.sv
module dtx_addr_class #(
  parameter int VA_W    = 64,
  parameter int VA_SIGN = 42,
  parameter int SZ_W    = 2,
  parameter int SP_HI   = 47,
  parameter int SP_LO   = 41,
  parameter logic [SP_HI-SP_LO:0] SP_TAG = 7'h7e,
  parameter int PA_W    = 44,
  parameter int UNC_BIT = 40
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic [SZ_W-1:0] size_code,
  output logic            misaligned,
  output logic            bad_va,
  output logic            is_super,
  output logic [PA_W-1:0] super_pa
);
  localparam int OFS_W = (1 << SZ_W) - 1;

  logic [OFS_W:0]   size_bytes;
  logic [OFS_W:0]   size_mask;
  logic [VA_W-1:VA_SIGN] upper;

  always_comb begin
    size_bytes = {{OFS_W{1'b0}}, 1'b1} << size_code;
    size_mask  = size_bytes - 1'b1;
    misaligned = |(vaddr[OFS_W-1:0] & size_mask[OFS_W-1:0]);
  end

  always_comb begin
    upper  = vaddr[VA_W-1:VA_SIGN];
    bad_va = !((&upper) || !(|upper));
  end

  always_comb begin
    is_super = (vaddr[SP_HI:SP_LO] == SP_TAG);
    super_pa = vaddr[PA_W-1:0];
    if (vaddr[UNC_BIT])
      super_pa[PA_W-1:UNC_BIT] = '1;
    else
      super_pa[PA_W-1:UNC_BIT] = '0;
  end
endmodule

// File: rtl/dtx_mode_sel.sv
module dtx_mode_sel
  import dtx_pkg::*;
(
  input  logic              pal_mode,
  input  logic              use_alt,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] alt_mode,
  output logic [MODE_W-1:0] eff_mode
);
  always_comb begin
    if (!pal_mode)
      eff_mode = cur_mode;
    else if (use_alt)
      eff_mode = alt_mode;
    else
      eff_mode = MODE_KERNEL;
  end
endmodule

// File: rtl/dtx_counters.sv
module dtx_counters #(
  parameter int N     = 6,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N-1:0]              inc,
  output logic [N-1:0][CNT_W-1:0]   cnt
);
  for (genvar i = 0; i < N; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)
        cnt[i] <= '0;
      else if (inc[i])
        cnt[i] <= cnt[i] + 1'b1;
    end

    // R9: a counter moves by at most one per cycle and never back
    assert_cnt_step_R9: assert property (@(posedge clk) disable iff (rst)
      (cnt[i] == $past(cnt[i])) || (cnt[i] == $past(cnt[i]) + CNT_W'(1)));
  end
endmodule

// File: rtl/dtx_fault_check.sv
module dtx_fault_check
  import dtx_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int VA_SIGN    = 42,
  parameter int PA_W       = 44,
  parameter int PAGE_SHIFT = 13,
  parameter int ASN_W      = 8,
  parameter int SZ_W       = 2,
  parameter int CNT_W      = 16,
  parameter int SP_HI      = 47,
  parameter int SP_LO      = 41,
  parameter logic [SP_HI-SP_LO:0] SP_TAG = 7'h7e,
  parameter int UNC_BIT    = 40,
  localparam int VPN_W     = VA_SIGN + 1 - PAGE_SHIFT,
  localparam int PPN_W     = PA_W - PAGE_SHIFT,
  localparam int NMODE     = 1 << MODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [SZ_W-1:0]   req_size,
  input  logic              req_write,
  input  logic              req_phys,
  input  logic              req_alt,
  input  logic              pal_mode,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] alt_mode,
  input  logic [ASN_W-1:0]  cur_asn,
  output logic              tlb_lookup,
  output logic [VPN_W-1:0]  tlb_vpn,
  output logic [ASN_W-1:0]  tlb_asn,
  input  logic              tlb_hit,
  input  logic [PPN_W-1:0]  tlb_ppn,
  input  logic [NMODE-1:0]  tlb_rd_en,
  input  logic [NMODE-1:0]  tlb_wr_en,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [1:0]        rsp_fault,
  output logic [ST_W-1:0]   rsp_status,
  output logic [CNT_W-1:0]  cnt_rd_acc,
  output logic [CNT_W-1:0]  cnt_wr_acc,
  output logic [CNT_W-1:0]  cnt_rd_miss,
  output logic [CNT_W-1:0]  cnt_wr_miss,
  output logic [CNT_W-1:0]  cnt_rd_acv,
  output logic [CNT_W-1:0]  cnt_wr_acv
);
  logic              misaligned, bad_va, is_super;
  logic [PA_W-1:0]   super_pa;
  logic [MODE_W-1:0] eff_mode;
  logic              xlate_path;
  logic              perm_ok;

  flt_e              nxt_fault;
  logic [ST_W-1:0]   nxt_status;
  logic [PA_W-1:0]   nxt_pa;
  logic [NCNT-1:0]   inc;
  logic [NCNT-1:0][CNT_W-1:0] cnt;

  dtx_addr_class #(
    .VA_W(VA_W), .VA_SIGN(VA_SIGN), .SZ_W(SZ_W), .SP_HI(SP_HI), .SP_LO(SP_LO),
    .SP_TAG(SP_TAG), .PA_W(PA_W), .UNC_BIT(UNC_BIT)
  ) u_class (
    .vaddr(req_vaddr), .size_code(req_size), .misaligned(misaligned),
    .bad_va(bad_va), .is_super(is_super), .super_pa(super_pa)
  );

  dtx_mode_sel u_mode (
    .pal_mode(pal_mode), .use_alt(req_alt), .cur_mode(cur_mode),
    .alt_mode(alt_mode), .eff_mode(eff_mode)
  );

  assign xlate_path = !misaligned && !req_phys && !bad_va && !is_super;
  assign tlb_lookup = req_valid && xlate_path;
  assign tlb_vpn    = req_vaddr[VA_SIGN:PAGE_SHIFT];
  assign tlb_asn    = cur_asn;
  assign perm_ok    = req_write ? tlb_wr_en[eff_mode] : tlb_rd_en[eff_mode];

  always_comb begin
    nxt_fault  = FLT_NONE;
    nxt_status = '0;
    nxt_pa     = '0;
    inc        = '0;
    if (misaligned) begin
      nxt_fault         = FLT_ALIGN;
      nxt_status[ST_WR] = req_write;
    end else if (req_phys) begin
      nxt_pa = req_vaddr[PA_W-1:0];
    end else if (bad_va) begin
      nxt_fault            = FLT_PAGE;
      nxt_status[ST_WR]    = req_write;
      nxt_status[ST_ACV]   = 1'b1;
      nxt_status[ST_BADVA] = 1'b1;
      inc[CI_RD_ACV + int'(req_write)] = req_valid;
    end else if (is_super) begin
      if (cur_mode != MODE_KERNEL) begin
        nxt_fault          = FLT_ACV;
        nxt_status[ST_WR]  = req_write;
        nxt_status[ST_ACV] = 1'b1;
        inc[CI_RD_ACV + int'(req_write)] = req_valid;
      end else begin
        nxt_pa = super_pa;
      end
    end else begin
      inc[CI_RD_ACC + int'(req_write)] = req_valid;
      if (!tlb_hit) begin
        nxt_fault         = FLT_PAGE;
        nxt_status[ST_WR] = req_write;
        inc[CI_RD_MISS + int'(req_write)] = req_valid;
      end else begin
        nxt_pa = {tlb_ppn, req_vaddr[PAGE_SHIFT-1:0]};
        if (!perm_ok) begin
          nxt_fault          = FLT_ACV;
          nxt_status[ST_WR]  = req_write;
          nxt_status[ST_ACV] = 1'b1;
          inc[CI_RD_ACV + int'(req_write)] = req_valid;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_fault  <= FLT_NONE;
      rsp_status <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr  <= nxt_pa;
        rsp_fault  <= nxt_fault;
        rsp_status <= nxt_status;
      end
    end
  end

  dtx_counters #(.N(NCNT), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(inc), .cnt(cnt)
  );

  assign cnt_rd_acc  = cnt[0];
  assign cnt_wr_acc  = cnt[1];
  assign cnt_rd_miss = cnt[2];
  assign cnt_wr_miss = cnt[3];
  assign cnt_rd_acv  = cnt[4];
  assign cnt_wr_acv  = cnt[5];

  // R1: misalignment always wins, status carries only the write bit
  assert_align_first_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid && misaligned |=> rsp_fault == FLT_ALIGN &&
      rsp_status == {{(ST_W-1){1'b0}}, $past(req_write)});

  // R3: a bad-address status always comes with a page fault and violation bit
  assert_badva_status_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_status[ST_BADVA] |-> rsp_fault == FLT_PAGE && rsp_status[ST_ACV]);

  // R4: kernel access to the direct-mapped window never faults
  assert_super_kernel_R4: assert property (@(posedge clk) disable iff (rst)
    req_valid && !misaligned && !req_phys && !bad_va && is_super &&
      cur_mode == MODE_KERNEL |=> rsp_fault == FLT_NONE);

  // R7: a miss on a lookup always reports a page fault
  assert_miss_page_R7: assert property (@(posedge clk) disable iff (rst)
    tlb_lookup && !tlb_hit |=> rsp_fault == FLT_PAGE && !rsp_status[ST_ACV]);

  // R9: no request, no result
  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
endmodule

// File: tb/dtx_fault_check_bench.sv
module dtx_fault_check_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0, req_phys = 1'b0, req_alt = 1'b0, pal_mode = 1'b0;
  logic [1:0]  cur_mode = '0, alt_mode = '0;
  logic [7:0]  cur_asn = 8'h5A;
  logic        tlb_lookup;
  logic [29:0] tlb_vpn;
  logic [7:0]  tlb_asn;
  logic        tlb_hit = 1'b0;
  logic [30:0] tlb_ppn = '0;
  logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
  logic        rsp_valid;
  logic [43:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic [3:0]  rsp_status;
  logic [15:0] cnt_rd_acc, cnt_wr_acc, cnt_rd_miss, cnt_wr_miss, cnt_rd_acv, cnt_wr_acv;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  dtx_fault_check u_dtx_fault_check (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_size(req_size), .req_write(req_write), .req_phys(req_phys),
    .req_alt(req_alt), .pal_mode(pal_mode), .cur_mode(cur_mode),
    .alt_mode(alt_mode), .cur_asn(cur_asn), .tlb_lookup(tlb_lookup),
    .tlb_vpn(tlb_vpn), .tlb_asn(tlb_asn), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
    .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_status(rsp_status),
    .cnt_rd_acc(cnt_rd_acc), .cnt_wr_acc(cnt_wr_acc), .cnt_rd_miss(cnt_rd_miss),
    .cnt_wr_miss(cnt_wr_miss), .cnt_rd_acv(cnt_rd_acv), .cnt_wr_acv(cnt_wr_acv)
  );

  // kind: 0 no counter, 1 access, 2 access+miss, 3 violation, 4 access+violation
  typedef struct packed {
    logic [63:0] va;
    logic [1:0]  sz;
    logic        wr, phys, alt, pal;
    logic [1:0]  cur, altm;
    logic        hit;
    logic [3:0]  rde, wre;
    logic [30:0] ppn;
    logic [1:0]  efault;
    logic [3:0]  estat;
    logic [43:0] epa;
    logic [2:0]  kind;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{64'h2008, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 4'h1, 4'h0, 31'd5, 2'd0, 4'h0, 44'hA008, 3'd1},
    '{64'h1002, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 4'hF, 4'hF, 31'd0, 2'd1, 4'h1, 44'h0, 3'd0},
    '{64'h1001, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 4'hF, 4'hF, 31'd0, 2'd1, 4'h0, 44'h0, 3'd0},
    '{64'h0000_0123_4567_8008, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 2'd0, 1'b0, 4'h0, 4'h0, 31'd0, 2'd0, 4'h0, 44'h123_4567_8008, 3'd0},
    '{64'h0000_0800_0000_0000, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 4'hF, 4'hF, 31'd1, 2'd2, 4'hA, 44'h0, 3'd3},
    '{64'h0000_0800_0000_0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 4'hF, 4'hF, 31'd1, 2'd2, 4'hB, 44'h0, 3'd3},
    '{64'hFFFF_FC00_0000_1000, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 4'h0, 4'h0, 31'd0, 2'd0, 4'h0, 44'h000_0000_1000, 3'd0},
    '{64'hFFFF_FC00_0000_1000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0, 1'b1, 4'hF, 4'hF, 31'd0, 2'd3, 4'h3, 44'h0, 3'd3},
    '{64'hFFFF_FC00_0000_1000, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 2'd0, 1'b1, 4'hF, 4'hF, 31'd0, 2'd3, 4'h2, 44'h0, 3'd3},
    '{64'h6000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 4'hF, 4'hF, 31'd0, 2'd2, 4'h1, 44'h0, 3'd2},
    '{64'h2000, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0, 1'b1, 4'h7, 4'hF, 31'd9, 2'd3, 4'h2, 44'h0, 3'd4},
    '{64'h4000, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 2'd0, 1'b1, 4'h1, 4'h0, 31'd3, 2'd0, 4'h0, 44'h6000, 3'd1},
    '{64'h8010, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 2'd2, 1'b1, 4'h0, 4'h4, 31'd1, 2'd0, 4'h0, 44'h2010, 3'd1},
    '{64'h8010, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 2'd1, 1'b1, 4'hF, 4'h4, 31'd1, 2'd3, 4'h3, 44'h0, 3'd4},
    '{64'h4, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 4'hF, 4'hF, 31'd0, 2'd1, 4'h0, 44'h0, 3'd0},
    '{64'hFFFF_FD00_0000_2000, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 4'h0, 4'h0, 31'd0, 2'd0, 4'h0, 44'hF00_0000_2000, 3'd0},
    '{64'hA000, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 2'd0, 1'b1, 4'h4, 4'h0, 31'd2, 2'd0, 4'h0, 44'h4000, 3'd1}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_for(input logic [1:0] f, input logic [2:0] k);
    case (f)
      2'd1:    return "R1";
      2'd2:    return (k == 3'd3) ? "R3" : "R7";
      2'd3:    return (k == 3'd3) ? "R4/R5" : "R8/R6";
      default: return (k == 3'd0) ? "R2/R4" : "R8/R6";
    endcase
  endfunction

  initial begin
    int e_racc = 0, e_wacc = 0, e_rmiss = 0, e_wmiss = 0, e_racv = 0, e_wacv = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check(rsp_valid == 1'b0, "R9 reset valid", 64'(rsp_valid), 64'd0);
    check({cnt_rd_acc, cnt_wr_acc, cnt_rd_miss, cnt_wr_miss, cnt_rd_acv, cnt_wr_acv} == '0,
          "R9 reset counters", 64'(cnt_rd_acc | cnt_wr_acc | cnt_rd_acv), 64'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      req_valid = 1'b1; req_vaddr = v.va; req_size = v.sz; req_write = v.wr;
      req_phys = v.phys; req_alt = v.alt; pal_mode = v.pal; cur_mode = v.cur;
      alt_mode = v.altm; tlb_hit = v.hit; tlb_rd_en = v.rde; tlb_wr_en = v.wre;
      tlb_ppn = v.ppn;
      #1;
      // R7: lookup issued only on the translated path, with page number and ASN
      if (v.kind == 3'd1 || v.kind == 3'd2 || v.kind == 3'd4) begin
        check(tlb_lookup && tlb_vpn == v.va[42:13] && tlb_asn == 8'h5A, "R7 lookup",
              64'({tlb_lookup, tlb_vpn}), 64'({1'b1, v.va[42:13]}));
        if (v.wr) e_wacc++; else e_racc++;
      end else begin
        check(!tlb_lookup, "R2/R3/R4 no lookup", 64'(tlb_lookup), 64'd0);
      end
      if (v.kind == 3'd2) begin if (v.wr) e_wmiss++; else e_rmiss++; end
      if (v.kind == 3'd3 || v.kind == 3'd4) begin if (v.wr) e_wacv++; else e_racv++; end
      @(posedge clk);
      @(negedge clk);
      check(rsp_valid && rsp_fault == v.efault, {tag_for(v.efault, v.kind), " fault"},
            64'(rsp_fault), 64'(v.efault));
      check(rsp_status == v.estat, {tag_for(v.efault, v.kind), " status"},
            64'(rsp_status), 64'(v.estat));
      if (v.efault == 2'd0)
        check(rsp_paddr == v.epa, {tag_for(v.efault, v.kind), " paddr"},
              64'(rsp_paddr), 64'(v.epa));
    end

    // R9: an idle cycle with a faulting address on the bus changes nothing
    req_valid = 1'b0; req_vaddr = 64'h0000_0800_0000_0001; req_size = 2'd3; req_phys = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!rsp_valid, "R9 idle valid", 64'(rsp_valid), 64'd0);
    check(cnt_rd_acc == 16'(e_racc), "R7 read access count", 64'(cnt_rd_acc), 64'(e_racc));
    check(cnt_wr_acc == 16'(e_wacc), "R7 write access count", 64'(cnt_wr_acc), 64'(e_wacc));
    check(cnt_rd_miss == 16'(e_rmiss), "R7 read miss count", 64'(cnt_rd_miss), 64'(e_rmiss));
    check(cnt_wr_miss == 16'(e_wmiss), "R7 write miss count", 64'(cnt_wr_miss), 64'(e_wmiss));
    check(cnt_rd_acv == 16'(e_racv), "R3/R8 read violation count", 64'(cnt_rd_acv), 64'(e_racv));
    check(cnt_wr_acv == 16'(e_wacv), "R3/R8 write violation count", 64'(cnt_wr_acv), 64'(e_wacv));

    // R9: reset mid-run clears counters
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(cnt_wr_acv == '0 && !rsp_valid, "R9 re-reset", 64'(cnt_wr_acv), 64'd0);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule